// File: doc/BRIEF.md
# Pulse-Width Bit Decoder

This block turns a pulse-width-modulated serial line into a stream of data bits. The line must rise at a steady rate, and each rising edge opens one bit period. The level of the line some time after that edge sets the bit: a long high pulse reads as 1 and a short one reads as 0.

An up-counter runs from a selectable division of the system clock and restarts from zero on every rising edge of the synchronised input. The counter is compared against a writable threshold. At the first match after each restart, a latch samples the synchronised line level into the decoded output, and a one-clock strobe marks the new bit.

The design does not measure the pulse width. It samples the level once, at a fixed delay after the edge. A stop bit, set at reset, holds the whole datapath idle until software clears it.

Top module: `pwm_bit_decoder`

## Requirements
- R1: After reset, the control register holds stop=1 (bit 0), clear mode 00 (bits 2:1) and clock select 000 (bits 5:3). Also after reset, `bit_out` and `bit_valid` are 0.
- R2: While the stop bit is 1, the counter and `bit_out` are held at 0 and `bit_valid` never pulses, whatever the input does.
- R3: The input passes through a two-flop synchroniser, and a rising edge is a 0 followed by a 1 there. The counter is cleared and a decision armed only when the clear-mode field is 11. With any other clear mode, no bits are produced.
- R4: Clock select value k advances the counter once every 2^(k-1) clocks for k from 1 to 7 (001 means every clock). Value 000 stops the counter.
- R5: The decoded bit equals the synchronised input level at the compare match. A wide pulse gives 1 and a narrow pulse gives 0. With clock select 001 and threshold T, a high pulse of T+2 clocks decodes as 1 and a pulse of T+1 clocks decodes as 0.
- R6: Exactly one decision is made per bit period. This holds even when the counter rests on the threshold value for several clocks.
- R7: `bit_out` keeps its value between decisions.
- R8: The threshold is written at address 1, and a new value governs the bit periods that start after the write.
- R9: `bit_valid` is high for exactly one clock, in the same cycle that `bit_out` first shows the new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects threshold |
| wr_data | input | CNT_W | Write data |
| pwm_in | input | 1 | Asynchronous pulse-width-modulated input |
| bit_out | output | 1 | Decoded data bit |
| bit_valid | output | 1 | One-clock strobe when a new bit is latched |

## Verification
The bench uses the defaults: an 8-bit counter and a 3-bit clock select. This gives access to every divider from 1 to 64 and to thresholds small enough that the exact decision clock with select 001 can be tested one clock either side of the boundary. A divide-by-4 run makes the counter rest on the threshold for several clocks, which exercises the one-decision-per-period rule. Changing the threshold between bursts shows the same pulse decoding differently under each value.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned PRE_W = (1 << SEL_W) - 2;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_RSV1 = 2'b01,
    CLR_RSV2 = 2'b10,
    CLR_RISE = 2'b11
  } clr_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0] clk_sel;
    clr_mode_e        clr_mode;
    logic             halt;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Mask of low prescaler bits that must all be 1 for a tick with select k.
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i + 2 <= int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic tick_of(input logic [SEL_W-1:0] sel,
                                   input logic [PRE_W-1:0] pre);
    logic [PRE_W-1:0] m;
    m = div_mask(sel);
    return (sel != '0) && ((pre & m) == m);
  endfunction
endpackage

// File: rtl/pwmdec_regs.sv
module pwmdec_regs
  import pwmdec_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] thr
);
  localparam ctrl_t CTRL_RST = '{clk_sel: '0, clr_mode: CLR_NONE, halt: 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
      thr  <= '0;
    end else if (wr_en) begin
      if (wr_addr) thr <= wr_data;
      else         ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  assert_rst_halt_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> ctrl.halt);
endmodule

// File: rtl/pwmdec_prescale.sv
module pwmdec_prescale
  import pwmdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (halt) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  assign tick = !halt && tick_of(clk_sel, pre_q);

  assert_div1_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == SEL_W'(1) && !halt) |-> tick);
  assert_sel0_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == '0) |-> !tick);
endmodule

// File: rtl/pwmdec_edge.sv
module pwmdec_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  output logic lvl,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pwm_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;

  assert_rise_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pwmdec_core.sv
module pwmdec_core
  import pwmdec_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  clr_mode_e        clr_mode,
  input  logic             tick,
  input  logic             rise,
  input  logic             lvl,
  input  logic [CNT_W-1:0] thr,
  output logic             bit_out,
  output logic             bit_valid,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             clr_ev;

  function automatic logic hit(input logic armed, input logic [CNT_W-1:0] cnt,
                               input logic [CNT_W-1:0] t, input logic clr);
    return armed && (cnt == t) && !clr;
  endfunction

  assign clr_ev = rise && (clr_mode == CLR_RISE);
  assign match  = !halt && hit(armed_q, cnt_q, thr, clr_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else if (halt) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= match;
      if (match) bit_out <= lvl;
      if (clr_ev) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else begin
        if (tick)  cnt_q   <= cnt_q + 1'b1;
        if (match) armed_q <= 1'b0;
      end
    end
  end

  assert_halt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (cnt_q == '0) && !bit_out && !bit_valid);
  assert_clear_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !halt) |=> (cnt_q == '0) && armed_q);
  assert_latch_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> bit_valid && (bit_out == $past(lvl)));
  assert_once_per_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !armed_q);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !halt) |=> $stable(bit_out));
  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(match));
endmodule

// File: rtl/pwm_bit_decoder.sv
module pwm_bit_decoder
  import pwmdec_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pwm_in,
  output logic             bit_out,
  output logic             bit_valid
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] thr;
  logic             tick, lvl, rise, match;

  pwmdec_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .thr(thr)
  );

  pwmdec_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .halt(ctrl.halt), .clk_sel(ctrl.clk_sel),
    .tick(tick)
  );

  pwmdec_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .lvl(lvl), .rise(rise)
  );

  pwmdec_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .halt(ctrl.halt), .clr_mode(ctrl.clr_mode),
    .tick(tick), .rise(rise), .lvl(lvl), .thr(thr),
    .bit_out(bit_out), .bit_valid(bit_valid), .match(match)
  );
endmodule

// File: tb/tb_pwm_bit_decoder.sv
module tb_pwm_bit_decoder;
  localparam int CNT_W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic pwm_in = 1'b0;
  logic bit_out, bit_valid;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  bit last_bit = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_bit_decoder #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_in(pwm_in), .bit_out(bit_out), .bit_valid(bit_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Control word: bit0 stop, bits2:1 clear mode, bits5:3 clock select.
  function automatic logic [CNT_W-1:0] ctrl_word(bit stop, logic [1:0] clr, logic [2:0] sel);
    return CNT_W'({sel, clr, stop});
  endfunction

  task automatic wr(input bit addr, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: one bit period, high for h clocks, total p clocks.
  task automatic send(input int h, input int p, input bit expect_bit, input bit expect_out);
    if (expect_out) exp_q.push_back(expect_bit);
    @(negedge clk);
    pwm_in = 1'b1;
    repeat (h) @(negedge clk);
    pwm_in = 1'b0;
    repeat (p - h - 1) @(negedge clk);
  endtask

  // Monitor: pop and compare each decoded bit (R5, R6, R9).
  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected bit_valid", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(bit_out == e, "R5 decoded bit", int'(bit_out), int'(e));
        last_bit = e;
      end
    end
  end

  // R9: strobe lasts one clock.
  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      @(negedge clk);
      check(!bit_valid, "R9 strobe width", int'(bit_valid), 0);
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_out == 1'b0 && bit_valid == 1'b0, "R1 reset outputs", int'(bit_out), 0);

    // R1/R2: stopped after reset, pulses produce nothing.
    wr(1'b1, 8'd4);
    wr(1'b0, ctrl_word(1'b0, 2'b00, 3'b001) | 8'h01);
    send(30, 40, 1'b1, 1'b0);
    check(bit_out == 1'b0, "R2 stop holds output", int'(bit_out), 0);

    // R3: enabled but clear mode 00 -> no bits.
    wr(1'b0, ctrl_word(1'b0, 2'b00, 3'b001));
    send(30, 40, 1'b1, 1'b0);
    send(30, 40, 1'b1, 1'b0);
    check(bit_out == 1'b0, "R3 no clear mode no bits", int'(bit_out), 0);

    // R5: select 001, threshold 4, mixed pulses and exact boundary.
    wr(1'b0, ctrl_word(1'b0, 2'b11, 3'b001));
    send(20, 30, 1'b1, 1'b1);
    check(bit_out == 1'b1, "R7 hold after 1", int'(bit_out), 1);
    send(2, 30, 1'b0, 1'b1);
    check(bit_out == 1'b0, "R7 hold after 0", int'(bit_out), 0);
    send(6, 30, 1'b1, 1'b1);   // T+2 -> 1
    send(5, 30, 1'b0, 1'b1);   // T+1 -> 0
    send(6, 30, 1'b1, 1'b1);
    check(bit_out == 1'b1, "R7 hold after boundary 1", int'(bit_out), 1);

    // R8: threshold 20 turns a 10-clock pulse into 0.
    send(10, 40, 1'b1, 1'b1);
    wr(1'b1, 8'd20);
    send(10, 40, 1'b0, 1'b1);
    send(30, 40, 1'b1, 1'b1);

    // R4/R6: divide by 4, threshold 5 (match near 20-24 clocks).
    wr(1'b1, 8'd5);
    wr(1'b0, ctrl_word(1'b0, 2'b11, 3'b011));
    send(3, 60, 1'b0, 1'b1);
    send(40, 60, 1'b1, 1'b1);
    send(12, 60, 1'b0, 1'b1);  // sampled near 21-25 clocks -> low
    send(35, 60, 1'b1, 1'b1);

    // R4: select 000 stops counter; threshold 5 never reached.
    wr(1'b0, ctrl_word(1'b0, 2'b11, 3'b000));
    send(40, 60, 1'b1, 1'b0);
    check(bit_out == 1'b1, "R4 stopped counter keeps last bit", int'(bit_out), 1);

    // R2: setting stop clears output.
    wr(1'b0, ctrl_word(1'b1, 2'b11, 3'b001));
    repeat (2) @(negedge clk);
    check(bit_out == 1'b0, "R2 stop clears output", int'(bit_out), 0);
    send(20, 30, 1'b1, 1'b0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6 all expected bits seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule